// File: doc/BRIEF.md
# Serial-Addressed SAR Conversion Sequencer

This block is the digital control for an 8-bit successive-approximation converter that has an 8-channel analog input multiplexer. A host drives a chip-select, a serial clock and a serial data line. The block waits for a start bit on that data line and takes in a short channel-assignment word. It then sets the multiplexer and runs one trial step per serial clock period against a 1-bit comparator input. Each decision goes out on the serial output as soon as it is made. The finished word is then sent out a second time with the least significant bit first.

The serial clock and chip select are sampled by a faster system clock, so every serial edge becomes a one-cycle event inside the block. The analog parts are outside the block. The trial-code output drives the capacitor/ladder DAC, and the comparator result comes back on `cmp_hi`. A parameter chooses how the LSB-first replay is paced. With the default, a shift-enable input holds or releases the replay. In the automatic variant, the replay starts on its own directly after the MSB-first stream.

Top module: `adc_sar_sequencer`

## Requirements
- R1: The block arms only on a high-to-low change of `cs_n`, and only from its cleared state. While armed it ignores `din`=0 on rising `sclk` edges, and the first `din`=1 it samples is the start bit.
- R2: The 4 bits that follow the start bit arrive in this order: mode (1 = single-ended), polarity, select[1], select[0]. The positive channel index is {select, polarity}. The negative input is the common terminal (`neg_com`=1) in single-ended mode and channel {select, ~polarity} in differential mode. Exactly one negative source is ever selected, and it is never the positive channel.
- R3: `busy` stays low at the rising edge that takes in the last address bit and rises at the next falling `sclk` edge. From then on `din` is ignored and the channel selects hold steady.
- R4: When `busy` rises, `dout_oe` goes high and `dout` drives 0 for that settling period.
- R5: At the settling edge the trial code becomes 0x80. At each of the next 8 falling edges the bit under test is kept if `cmp_hi`=1 and cleared otherwise, and the next lower bit is set. After the 8th edge the trial code equals the result.
- R6: Each decision appears on `dout` at the falling edge that makes it, MSB first.
- R7: `busy` falls at the first rising `sclk` edge after the 8th decision.
- R8: With `AUTO_SHIFT`=0, a falling edge with `shift_en`=1 leaves the LSB on `dout`. Each falling edge with `shift_en`=0 moves to the next higher bit. After bit 7 has been shown, `dout` reads 0 until chip select rises.
- R9: If `cmp_hi` stays low for the whole conversion (positive input below negative), the result is 0x00.
- R10: When `cs_n`=1 and `sclk`=1 together for `RST_CYC` system clocks, every internal register is cleared. Without that, a new `cs_n` fall does not start a conversion.
- R11: `dout_oe` is low whenever `cs_n` is high, and `dout` then reads 0.
- R12: With `AUTO_SHIFT`=1, the replay ignores `shift_en` and advances one bit on every falling edge after `busy` falls, so the LSB is not repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial start bit and channel assignment |
| shift_en | input | 1 | Low lets the LSB-first replay advance (AUTO_SHIFT=0) |
| cmp_hi | input | 1 | Comparator: 1 when the input is above the trial level |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for the serial data pad |
| busy | output | 1 | High while a conversion is running |
| trial | output | W | Trial code for the DAC |
| pos_sel | output | NCH | One-hot positive channel select |
| neg_sel | output | NCH | One-hot negative channel select (differential) |
| neg_com | output | 1 | Common terminal is the negative input |

## Verification
A mistake in capturing the address shows up at the first falling edge after the address: wrong or non-one-hot channel selects, or a `busy` that rises early, late or not at all. A step counter that is off by one shows up as a `busy` fall at the wrong rising edge, and as a trial code that does not match the bits already sent. A mistake in the trial register shows up on `dout` within the same serial period, because every decision is streamed out immediately. A fault in the replay register or in the clear path appears during the tail of the transaction or at the next chip select, through a repeated or missing LSB, a non-zero tail, or a conversion that restarts without the clear.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_ADDR,
    ST_SETTLE,
    ST_CONV,
    ST_LAST,
    ST_OUT
  } seq_state_t;
endpackage

// File: rtl/adc_seq_edges.sv
// Turns the host's serial pins into single-cycle edge events and detects
// the clear condition (chip select high with serial clock high).
module adc_seq_edges #(
  parameter int RST_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic clear
);
  localparam int CW = $clog2(RST_CYC + 1);

  logic          sclk_q, cs_q;
  logic [CW-1:0] hold_cnt_q, hold_cnt_n;
  logic          hold_cond;

  assign hold_cond = cs_n && sclk;

  always_comb begin
    hold_cnt_n = hold_cnt_q;
    if (!hold_cond)
      hold_cnt_n = '0;
    else if (hold_cnt_q != CW'(RST_CYC))
      hold_cnt_n = hold_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      hold_cnt_q <= '0;
    end else begin
      sclk_q     <= sclk;
      cs_q       <= cs_n;
      hold_cnt_q <= hold_cnt_n;
    end
  end

  assign sclk_rise = !cs_n && sclk && !sclk_q;
  assign sclk_fall = !cs_n && !sclk && sclk_q;
  assign cs_fall   = !cs_n && cs_q;
  assign clear     = hold_cond && (hold_cnt_q == CW'(RST_CYC - 1));
endmodule

// File: rtl/adc_seq_decode.sv
// Channel-assignment decode: addr = {mode, polarity, select}.
module adc_seq_decode #(
  parameter int NCH = 8
) (
  input  logic [$clog2(NCH):0] addr,
  input  logic                 valid,
  output logic [NCH-1:0]       pos_sel,
  output logic [NCH-1:0]       neg_sel,
  output logic                 neg_com
);
  localparam int CHW  = $clog2(NCH);
  localparam int SELW = CHW - 1;

  logic            single_ended;
  logic            polarity;
  logic [SELW-1:0] pair;
  logic [CHW-1:0]  pos_idx, neg_idx;

  assign single_ended = addr[CHW];
  assign polarity     = addr[SELW];
  assign pair         = addr[SELW-1:0];
  assign pos_idx      = {pair, polarity};
  assign neg_idx      = {pair, ~polarity};
  assign neg_com      = valid && single_ended;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign pos_sel[i] = valid && (pos_idx == CHW'(i));
    assign neg_sel[i] = valid && !single_ended && (neg_idx == CHW'(i));
  end
endmodule

// File: rtl/adc_seq_core.sv
// Successive-approximation trial register with a one-hot bit pointer.
module adc_seq_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic         step,
  input  logic         cmp_hi,
  output logic [W-1:0] trial,
  output logic         last
);
  logic [W-1:0] trial_q, trial_n, mask_q, mask_n;

  always_comb begin
    trial_n = trial_q;
    mask_n  = mask_q;
    if (clear) begin
      trial_n = '0;
      mask_n  = '0;
    end else if (load) begin
      trial_n = {1'b1, {(W-1){1'b0}}};
      mask_n  = {1'b1, {(W-1){1'b0}}};
    end else if (step) begin
      trial_n = (trial_q & ~mask_q) | (cmp_hi ? mask_q : '0) | (mask_q >> 1);
      mask_n  = mask_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      mask_q  <= '0;
    end else begin
      trial_q <= trial_n;
      mask_q  <= mask_n;
    end
  end

  assign trial = trial_q;
  assign last  = mask_q[0];
endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer #(
  parameter int W          = 8,
  parameter int NCH        = 8,
  parameter int RST_CYC    = 3,
  parameter bit AUTO_SHIFT = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic           din,
  input  logic           shift_en,
  input  logic           cmp_hi,
  output logic           dout,
  output logic           dout_oe,
  output logic           busy,
  output logic [W-1:0]   trial,
  output logic [NCH-1:0] pos_sel,
  output logic [NCH-1:0] neg_sel,
  output logic           neg_com
);
  import adc_seq_pkg::*;

  localparam int ADDR_W = $clog2(NCH) + 1;
  localparam int ACW    = $clog2(ADDR_W);

  seq_state_t        st_q, st_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [ACW-1:0]    acnt_q, acnt_n;
  logic              dout_q, dout_n;
  logic [W-1:0]      osr_q, osr_n;
  logic              sclk_rise, sclk_fall, cs_fall, clear;
  logic              load, step, last, shift_go, sel_valid;

  adc_seq_edges #(.RST_CYC(RST_CYC)) u_edges (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .clear(clear)
  );

  adc_seq_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .step(step),
    .cmp_hi(cmp_hi), .trial(trial), .last(last)
  );

  adc_seq_decode #(.NCH(NCH)) u_decode (
    .addr(addr_q), .valid(sel_valid),
    .pos_sel(pos_sel), .neg_sel(neg_sel), .neg_com(neg_com)
  );

  if (AUTO_SHIFT) begin : g_auto
    assign shift_go = 1'b1;
  end else begin : g_gated
    assign shift_go = !shift_en;
  end

  always_comb begin
    st_n   = st_q;
    addr_n = addr_q;
    acnt_n = acnt_q;
    dout_n = dout_q;
    osr_n  = osr_q;
    load   = 1'b0;
    step   = 1'b0;
    case (st_q)
      ST_IDLE:   if (cs_fall) st_n = ST_HUNT;
      ST_HUNT:   if (sclk_rise && din) begin
                   st_n   = ST_ADDR;
                   acnt_n = '0;
                 end
      ST_ADDR:   if (sclk_rise) begin
                   addr_n = {addr_q[ADDR_W-2:0], din};
                   acnt_n = acnt_q + 1'b1;
                   if (acnt_q == ACW'(ADDR_W - 1)) st_n = ST_SETTLE;
                 end
      ST_SETTLE: if (sclk_fall) begin
                   load   = 1'b1;
                   dout_n = 1'b0;
                   st_n   = ST_CONV;
                 end
      ST_CONV:   if (sclk_fall) begin
                   step   = 1'b1;
                   dout_n = cmp_hi;
                   if (last) st_n = ST_LAST;
                 end
      ST_LAST:   if (sclk_rise) begin
                   osr_n = trial;
                   st_n  = ST_OUT;
                 end
      ST_OUT:    if (sclk_fall && shift_go) osr_n = osr_q >> 1;
      default:   st_n = ST_IDLE;
    endcase
    if (clear) begin
      st_n   = ST_IDLE;
      addr_n = '0;
      acnt_n = '0;
      dout_n = 1'b0;
      osr_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      acnt_q <= '0;
      dout_q <= 1'b0;
      osr_q  <= '0;
    end else begin
      st_q   <= st_n;
      addr_q <= addr_n;
      acnt_q <= acnt_n;
      dout_q <= dout_n;
      osr_q  <= osr_n;
    end
  end

  assign busy      = (st_q == ST_CONV) || (st_q == ST_LAST);
  assign sel_valid = busy || (st_q == ST_SETTLE) || (st_q == ST_OUT);
  assign dout_oe   = !cs_n && (busy || (st_q == ST_OUT));
  assign dout      = dout_oe && ((st_q == ST_OUT) ? osr_q[0] : dout_q);
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_n,
  input logic           busy,
  input logic           dout,
  input logic           dout_oe,
  input logic [NCH-1:0] pos_sel,
  input logic [NCH-1:0] neg_sel,
  input logic           neg_com
);
  assert_pad_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!dout_oe && !dout));

  assert_busy_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cs_n) |-> dout_oe);

  assert_lead_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !dout);

  assert_pos_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(pos_sel) == 1));

  assert_neg_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (($countones(neg_sel) + 32'(neg_com)) == 1 && (pos_sel & neg_sel) == '0));

  assert_sel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(pos_sel) && $stable(neg_sel) && $stable(neg_com)));
endmodule

bind adc_sar_sequencer adc_seq_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy), .dout(dout),
  .dout_oe(dout_oe), .pos_sel(pos_sel), .neg_sel(neg_sel), .neg_com(neg_com)
);

// File: tb/adc_sar_sequencer_test.sv
module adc_sar_sequencer_test;
  localparam int H       = 4;
  localparam int RST_CYC = 3;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, din, shift_en;
  logic [7:0] vin;
  logic flo;
  logic dout, dout_oe, busy, neg_com;
  logic [7:0] trial, pos_sel, neg_sel;
  logic dout_a, dout_oe_a, busy_a, neg_com_a;
  logic [7:0] trial_a, pos_sel_a, neg_sel_a;
  logic cmp_m, cmp_a;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // comparator model: input above the trial level
  assign cmp_m = !flo && (vin >= trial);
  assign cmp_a = !flo && (vin >= trial_a);

  adc_sar_sequencer #(.RST_CYC(RST_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .shift_en(shift_en), .cmp_hi(cmp_m), .dout(dout), .dout_oe(dout_oe),
    .busy(busy), .trial(trial), .pos_sel(pos_sel), .neg_sel(neg_sel),
    .neg_com(neg_com)
  );

  adc_sar_sequencer #(.RST_CYC(RST_CYC), .AUTO_SHIFT(1'b1)) uut_auto (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .shift_en(shift_en), .cmp_hi(cmp_a), .dout(dout_a), .dout_oe(dout_oe_a),
    .busy(busy_a), .trial(trial_a), .pos_sel(pos_sel_a), .neg_sel(neg_sel_a),
    .neg_com(neg_com_a)
  );

  // {addr[3:0], vin[7:0], leading zeros[1:0], hold falls[1:0]}
  localparam logic [15:0] VEC [6] = '{
    {4'b1000, 8'hA5, 2'd0, 2'd0},
    {4'b1111, 8'h3C, 2'd2, 2'd2},
    {4'b0010, 8'hFF, 2'd1, 2'd1},
    {4'b0101, 8'h01, 2'd3, 2'd0},
    {4'b1100, 8'h80, 2'd0, 2'd3},
    {4'b0111, 8'h7F, 2'd1, 2'd1}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    din = b;
    sclk = 1'b0;
    wait_clk(H);
    sclk = 1'b1;
    wait_clk(H);
  endtask

  task automatic clear_seq();
    sclk = 1'b0;
    cs_n = 1'b1;
    wait_clk(H);
    sclk = 1'b1;
    wait_clk(RST_CYC + 3);
    sclk = 1'b0;
    wait_clk(H);
  endtask

  task automatic run_txn(input logic [3:0] a, input logic [7:0] v, input int lead,
                         input int hold, input bit force_low, input bit do_clear);
    logic [7:0] expw, exp_pos, exp_neg, exp_tr;
    int k;
    vin = v;
    flo = force_low;
    expw = force_low ? 8'h00 : v;
    exp_pos = 8'h01 << {a[1:0], a[2]};
    exp_neg = a[3] ? 8'h00 : (8'h01 << {a[1:0], ~a[2]});
    shift_en = 1'b1;
    cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < lead; i++) send_bit(1'b0);
    send_bit(1'b1);
    for (int i = 3; i >= 0; i--) send_bit(a[i]);
    check(busy == 1'b0, "R3 busy low before settling edge", busy, 0);
    din = 1'b1;
    sclk = 1'b0;
    wait_clk(H);
    check(busy && busy_a, "R1 R3 busy after start+address", busy, 1);
    check(dout_oe == 1'b1 && dout == 1'b0, "R4 leading zero driven", {dout_oe, dout}, 2);
    check(pos_sel == exp_pos, "R2 positive select", pos_sel, exp_pos);
    check(neg_sel == exp_neg && neg_com == a[3], "R2 negative select", {neg_com, neg_sel},
          {a[3], exp_neg});
    check(trial == 8'h80, "R5 initial trial", trial, 8'h80);
    for (int i = 7; i >= 0; i--) begin
      din = ~din;
      sclk = 1'b1;
      wait_clk(H);
      sclk = 1'b0;
      wait_clk(H);
      exp_tr = (expw & ~((8'h01 << i) - 8'h01)) | ((i > 0) ? (8'h01 << (i - 1)) : 8'h00);
      check(dout == expw[i] && dout_a == expw[i], "R6 MSB-first decision", dout, expw[i]);
      check(trial == exp_tr, force_low ? "R9 trial with comparator low" : "R5 trial step",
            trial, exp_tr);
    end
    check(busy == 1'b1, "R7 busy held through 8th decision", busy, 1);
    sclk = 1'b1;
    wait_clk(H);
    check(busy == 1'b0 && busy_a == 1'b0, "R7 busy falls at next rise", busy, 0);
    check(dout == expw[0], "R8 LSB shown after busy", dout, expw[0]);
    if (force_low) check(trial == 8'h00, "R9 result zero", trial, 0);
    k = 0;
    for (int j = 0; j < hold; j++) begin
      sclk = 1'b0;
      wait_clk(H);
      k++;
      check(dout == expw[0], "R8 shift_en high holds LSB", dout, expw[0]);
      check(dout_a == ((k < 8) ? expw[k] : 1'b0), "R12 auto replay", dout_a,
            (k < 8) ? expw[k] : 0);
      sclk = 1'b1;
      wait_clk(H);
    end
    shift_en = 1'b0;
    for (int j = 1; j <= 9; j++) begin
      sclk = 1'b0;
      wait_clk(H);
      k++;
      check(dout == ((j < 8) ? expw[j] : 1'b0), "R8 LSB-first replay", dout,
            (j < 8) ? expw[j] : 0);
      check(dout_a == ((k < 8) ? expw[k] : 1'b0), "R12 auto replay", dout_a,
            (k < 8) ? expw[k] : 0);
      sclk = 1'b1;
      wait_clk(H);
    end
    sclk = 1'b0;
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(H);
    check(dout_oe == 1'b0 && dout == 1'b0 && dout_oe_a == 1'b0, "R11 pad off with cs high",
          dout_oe, 0);
    if (do_clear) clear_seq();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b1;
    sclk = 1'b0;
    din = 1'b0;
    shift_en = 1'b1;
    vin = 8'h00;
    flo = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    check(busy == 0 && dout_oe == 0 && trial == 0 && pos_sel == 0,
          "R10 reset state", {busy, dout_oe, trial}, 0);

    for (int n = 0; n < 6; n++)
      run_txn(VEC[n][15:12], VEC[n][11:4], int'(VEC[n][3:2]), int'(VEC[n][1:0]), 1'b0, 1'b1);

    // R9: positive input below negative, comparator never high
    run_txn(4'b1000, 8'hC3, 1, 0, 1'b1, 1'b1);

    // R10: without the clear condition a new chip select does not restart
    run_txn(4'b0011, 8'h5A, 0, 0, 1'b0, 1'b0);
    sclk = 1'b0;
    wait_clk(6);
    cs_n = 1'b0;
    wait_clk(H);
    send_bit(1'b1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    sclk = 1'b0;
    wait_clk(H);
    check(busy == 1'b0, "R10 no restart without clear", busy, 0);
    cs_n = 1'b1;
    wait_clk(H);
    // clock high for too short a time: no clear
    sclk = 1'b1;
    wait_clk(RST_CYC - 1);
    sclk = 1'b0;
    wait_clk(H);
    cs_n = 1'b0;
    wait_clk(H);
    send_bit(1'b1);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    sclk = 1'b0;
    wait_clk(H);
    check(busy == 1'b0, "R10 short clock-high does not clear", busy, 0);
    clear_seq();
    check(trial == 8'h00 && pos_sel == 8'h00, "R10 registers cleared", trial, 0);
    run_txn(4'b1011, 8'h96, 2, 1, 1'b0, 1'b1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule